// File: doc/BRIEF.md
# Render Bus Gate and Interrupt Status

This block sits on the master request path of a rendering engine, just in front of the memory bus. Each request that the engine presents is either forwarded to the bus one cycle later or held back. Several conditions can close the gate. A stop command or a performance counter crossing its limit closes it until a start command. An enabled write window that is violated closes it until the window registers change. An error response or a forced-hang command closes it until reset. A watchdog hint only raises a status bit and never closes the gate.

Every condition sets its own bit in a sticky raw status word. Software clears a bit by writing a one to it. An interrupt line is raised whenever a set status bit is also enabled in the mask. The bus-stopped bit is not set when the stop is requested. It is set only after every issued transaction has returned a response while the gate is held closed by a stop command or a counter limit.

Top module: `rbg_top`

## Requirements
- R1: A request with `req_valid_i` high in a cycle where `req_ready_o` is high, and that does not violate the write window, appears on `bus_valid_o`, `bus_addr_o` and `bus_write_o` after the next clock edge. While `req_ready_o` is low, `bus_valid_o` stays low one cycle later.
- R2: A `stop_cmd_i` pulse drives `req_ready_o` low after the next edge. Status bit 0 (bus stopped) is set one edge after the outstanding count (issued requests minus `resp_valid_i` responses) reaches zero while stopped, and never earlier.
- R3: When `cnt0_i` becomes strictly greater than `lim0_i`, status bit 1 is set and the gate closes after that edge. The same holds for `cnt1_i`/`lim1_i` with status bit 2. A value that stays above its limit does not set the bit again.
- R4: A `start_cmd_i` pulse reopens a gate that was closed by a stop command or a counter limit. If start and stop arrive in the same cycle, the stop wins.
- R5: While `wb_en_i` is high, a write whose address is below `wb_lo_i` or above `wb_hi_i` (both bounds inclusive-legal) is dropped and sets status bit 3. The gate then stays closed until `wb_lo_i`, `wb_hi_i` or `wb_en_i` changes. Reads and in-window writes pass.
- R6: A cycle with both `resp_valid_i` and `resp_err_i` high sets status bit 4 and closes the gate until reset. `start_cmd_i` has no effect on it.
- R7: A `force_hang_i` pulse sets status bit 5 and closes the gate until reset. `start_cmd_i` has no effect on it.
- R8: A `wdog_hit_i` pulse sets status bit 6 and leaves `req_ready_o` and request forwarding unchanged.
- R9: Status bits are sticky. A cycle with `clr_we_i` high clears the bits that are one in `clr_data_i`, leaves the other bits alone, and a new event in the same cycle keeps its bit set.
- R10: `irq_o` is high in exactly the cycles where `raw_stat_o & mask_i` (mask as sampled at the previous edge) is non-zero. It updates on the same edge as the status word.
- R11: After a synchronous reset, `raw_stat_o` and `irq_o` are 0, `bus_valid_o` is 0 and `req_ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Engine request valid |
| req_addr_i | input | AW | Engine request address |
| req_write_i | input | 1 | Request is a write |
| req_ready_o | output | 1 | Gate open, request can be taken |
| bus_valid_o | output | 1 | Forwarded request valid |
| bus_addr_o | output | AW | Forwarded request address |
| bus_write_o | output | 1 | Forwarded request is a write |
| resp_valid_i | input | 1 | One transaction completed |
| resp_err_i | input | 1 | Completion carried an error |
| stop_cmd_i | input | 1 | Stop-bus command pulse |
| start_cmd_i | input | 1 | Start-bus command pulse |
| force_hang_i | input | 1 | Forced-hang command pulse |
| wdog_hit_i | input | 1 | Watchdog limit reached pulse |
| cnt0_i | input | CW | Performance counter 0 value |
| lim0_i | input | CW | Limit for counter 0 |
| cnt1_i | input | CW | Performance counter 1 value |
| lim1_i | input | CW | Limit for counter 1 |
| wb_lo_i | input | AW | Lowest legal write address |
| wb_hi_i | input | AW | Highest legal write address |
| wb_en_i | input | 1 | Write-window check enable |
| clr_we_i | input | 1 | Write-one-to-clear strobe |
| clr_data_i | input | 7 | Bits to clear |
| mask_i | input | 7 | Interrupt enable per status bit |
| raw_stat_o | output | 7 | Sticky raw status word |
| irq_o | output | 1 | Interrupt line |

## Verification
Forwarding, gate closing, event bits and the interrupt all appear one edge after the stimulus cycle. The bus-stopped bit appears one edge after the last response, so after a counter limit it shows up one cycle later than the limit bit. The bench drives inputs on the falling edge and samples on the next falling edge. Each check therefore lands exactly on the cycle in which the result is due. For the drain case the bench also checks the cycles before the due cycle, to show that the stopped bit does not appear early.

// File: rtl/rbg_pkg.sv
package rbg_pkg;
  localparam int NSRC     = 7;
  localparam int B_STOP   = 0;
  localparam int B_LIM0   = 1;
  localparam int B_LIM1   = 2;
  localparam int B_WBERR  = 3;
  localparam int B_BUSERR = 4;
  localparam int B_FHANG  = 5;
  localparam int B_WDOG   = 6;
  typedef logic [NSRC-1:0] stat_t;
endpackage

// File: rtl/rbg_limit.sv
module rbg_limit #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] lim_i,
  output logic          hit_o
);
  logic over, over_q;

  assign over  = cnt_i > lim_i;
  assign hit_o = over & ~over_q;

  always_ff @(posedge clk) begin
    if (rst) over_q <= 1'b0;
    else     over_q <= over;
  end
endmodule

// File: rtl/rbg_gate.sv
module rbg_gate #(
  parameter int AW = 32,
  parameter int OW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic          req_write_i,
  output logic          req_ready_o,
  output logic          bus_valid_o,
  output logic [AW-1:0] bus_addr_o,
  output logic          bus_write_o,
  input  logic          resp_valid_i,
  input  logic          stop_i,
  input  logic          start_i,
  input  logic          fatal_i,
  input  logic [AW-1:0] wb_lo_i,
  input  logic [AW-1:0] wb_hi_i,
  input  logic          wb_en_i,
  output logic          wb_evt_o,
  output logic          stop_evt_o
);
  localparam logic [OW-1:0] OMAX = {OW{1'b1}};

  logic          soft_q, wb_blk_q, fatal_q, seen_q;
  logic [OW-1:0] outst_q;
  logic [AW-1:0] lo_q, hi_q;
  logic          en_q;
  logic          gate_open, viol, accept, dec, changed;

  assign gate_open   = ~soft_q & ~wb_blk_q & ~fatal_q;
  assign req_ready_o = gate_open & (outst_q != OMAX);
  assign viol        = wb_en_i & req_write_i &
                       ((req_addr_i < wb_lo_i) | (req_addr_i > wb_hi_i));
  assign accept      = req_valid_i & req_ready_o & ~viol;
  assign wb_evt_o    = req_valid_i & req_ready_o & viol;
  assign dec         = resp_valid_i & (outst_q != '0);
  assign changed     = (wb_en_i != en_q) | (wb_lo_i != lo_q) | (wb_hi_i != hi_q);
  assign stop_evt_o  = soft_q & (outst_q == '0) & ~seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_valid_o <= 1'b0;
      bus_addr_o  <= '0;
      bus_write_o <= 1'b0;
      outst_q     <= '0;
      soft_q      <= 1'b0;
      seen_q      <= 1'b0;
      wb_blk_q    <= 1'b0;
      fatal_q     <= 1'b0;
      lo_q        <= '0;
      hi_q        <= '0;
      en_q        <= 1'b0;
    end else begin
      bus_valid_o <= accept;
      if (accept) begin
        bus_addr_o  <= req_addr_i;
        bus_write_o <= req_write_i;
      end
      if (accept && !dec)      outst_q <= outst_q + 1'b1;
      else if (!accept && dec) outst_q <= outst_q - 1'b1;

      if (stop_i)       soft_q <= 1'b1;
      else if (start_i) soft_q <= 1'b0;

      seen_q <= soft_q & (seen_q | stop_evt_o);

      if (wb_evt_o)     wb_blk_q <= 1'b1;
      else if (changed) wb_blk_q <= 1'b0;

      if (fatal_i) fatal_q <= 1'b1;

      lo_q <= wb_lo_i;
      hi_q <= wb_hi_i;
      en_q <= wb_en_i;
    end
  end

  // R1: a closed gate forwards nothing on the following edge
  p_closed_no_issue_r1: assert property (@(posedge clk) disable iff (rst)
    !req_ready_o |=> !bus_valid_o);

  // R5: a window violation is never forwarded
  p_window_drop_r5: assert property (@(posedge clk) disable iff (rst)
    wb_evt_o |=> !bus_valid_o);

  // R6 / R7: the fatal hold only leaves through reset
  p_fatal_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    fatal_q |=> fatal_q);
endmodule

// File: rtl/rbg_status.sv
module rbg_status
  import rbg_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  stat_t evt_i,
  input  logic  clr_we_i,
  input  stat_t clr_data_i,
  input  stat_t mask_i,
  output stat_t stat_o,
  output logic  irq_o
);
  stat_t clr_bits, nxt;

  assign clr_bits = clr_we_i ? clr_data_i : '0;
  assign nxt      = (stat_o & ~clr_bits) | evt_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_o <= '0;
      irq_o  <= 1'b0;
    end else begin
      stat_o <= nxt;
      irq_o  <= |(nxt & mask_i);
    end
  end

  // R10: the interrupt line needs a set status bit behind it
  p_irq_needs_stat_r10: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (stat_o != '0));
endmodule

// File: rtl/rbg_top.sv
module rbg_top
  import rbg_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int OW = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid_i,
  input  logic [AW-1:0]   req_addr_i,
  input  logic            req_write_i,
  output logic            req_ready_o,
  output logic            bus_valid_o,
  output logic [AW-1:0]   bus_addr_o,
  output logic            bus_write_o,
  input  logic            resp_valid_i,
  input  logic            resp_err_i,
  input  logic            stop_cmd_i,
  input  logic            start_cmd_i,
  input  logic            force_hang_i,
  input  logic            wdog_hit_i,
  input  logic [CW-1:0]   cnt0_i,
  input  logic [CW-1:0]   lim0_i,
  input  logic [CW-1:0]   cnt1_i,
  input  logic [CW-1:0]   lim1_i,
  input  logic [AW-1:0]   wb_lo_i,
  input  logic [AW-1:0]   wb_hi_i,
  input  logic            wb_en_i,
  input  logic            clr_we_i,
  input  logic [NSRC-1:0] clr_data_i,
  input  logic [NSRC-1:0] mask_i,
  output logic [NSRC-1:0] raw_stat_o,
  output logic            irq_o
);
  localparam int NCNT = 2;

  logic [CW-1:0]   cnt_a [NCNT];
  logic [CW-1:0]   lim_a [NCNT];
  logic [NCNT-1:0] lim_hit;
  logic            wb_evt, stop_evt, bus_err;
  stat_t           evt;

  assign cnt_a[0] = cnt0_i;
  assign cnt_a[1] = cnt1_i;
  assign lim_a[0] = lim0_i;
  assign lim_a[1] = lim1_i;

  for (genvar g = 0; g < NCNT; g++) begin : g_lim
    rbg_limit #(.CW(CW)) u_lim (
      .clk   (clk),
      .rst   (rst),
      .cnt_i (cnt_a[g]),
      .lim_i (lim_a[g]),
      .hit_o (lim_hit[g])
    );
  end

  assign bus_err = resp_valid_i & resp_err_i;

  rbg_gate #(.AW(AW), .OW(OW)) u_gate (
    .clk          (clk),
    .rst          (rst),
    .req_valid_i  (req_valid_i),
    .req_addr_i   (req_addr_i),
    .req_write_i  (req_write_i),
    .req_ready_o  (req_ready_o),
    .bus_valid_o  (bus_valid_o),
    .bus_addr_o   (bus_addr_o),
    .bus_write_o  (bus_write_o),
    .resp_valid_i (resp_valid_i),
    .stop_i       (stop_cmd_i | (|lim_hit)),
    .start_i      (start_cmd_i),
    .fatal_i      (force_hang_i | bus_err),
    .wb_lo_i      (wb_lo_i),
    .wb_hi_i      (wb_hi_i),
    .wb_en_i      (wb_en_i),
    .wb_evt_o     (wb_evt),
    .stop_evt_o   (stop_evt)
  );

  always_comb begin
    evt           = '0;
    evt[B_STOP]   = stop_evt;
    evt[B_LIM0]   = lim_hit[0];
    evt[B_LIM1]   = lim_hit[1];
    evt[B_WBERR]  = wb_evt;
    evt[B_BUSERR] = bus_err;
    evt[B_FHANG]  = force_hang_i;
    evt[B_WDOG]   = wdog_hit_i;
  end

  rbg_status u_stat (
    .clk        (clk),
    .rst        (rst),
    .evt_i      (evt),
    .clr_we_i   (clr_we_i),
    .clr_data_i (clr_data_i),
    .mask_i     (mask_i),
    .stat_o     (raw_stat_o),
    .irq_o      (irq_o)
  );

  // R2: the stopped bit only rises after the gate was already closed
  p_stopped_after_close_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(raw_stat_o[B_STOP]) |-> $past(!req_ready_o));
endmodule

// File: tb/rbg_top_bench.sv
`timescale 1ns/1ps
module rbg_top_bench;
  localparam int AW = 32;
  localparam int CW = 16;
  localparam int NS = 7;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid_i = 0, req_write_i = 0;
  logic [AW-1:0] req_addr_i = '0;
  logic          req_ready_o, bus_valid_o, bus_write_o, irq_o;
  logic [AW-1:0] bus_addr_o;
  logic          resp_valid_i = 0, resp_err_i = 0;
  logic          stop_cmd_i = 0, start_cmd_i = 0, force_hang_i = 0, wdog_hit_i = 0;
  logic [CW-1:0] cnt0_i = '0, lim0_i = '1, cnt1_i = '0, lim1_i = '1;
  logic [AW-1:0] wb_lo_i = '0, wb_hi_i = '0;
  logic          wb_en_i = 0, clr_we_i = 0;
  logic [NS-1:0] clr_data_i = '0, mask_i = '0, raw_stat_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rbg_top u_rbg_top (.*);

  // {drop, write, address}
  localparam logic [33:0] VEC [6] = '{
    {1'b0, 1'b1, 32'h0000_0100},
    {1'b1, 1'b1, 32'h0000_00FF},
    {1'b0, 1'b0, 32'h0000_0050},
    {1'b0, 1'b1, 32'h0000_01FF},
    {1'b1, 1'b1, 32'h0000_0200},
    {1'b0, 1'b1, 32'h0000_0180}
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    tick();
    tick();
    rst = 1'b0;
  endtask

  task automatic clear_all();
    clr_we_i = 1'b1; clr_data_i = '1;
    tick();
    clr_we_i = 1'b0; clr_data_i = '0;
  endtask

  task automatic issue(input logic [31:0] a, input logic w);
    req_valid_i = 1'b1; req_addr_i = a; req_write_i = w;
    tick();
    req_valid_i = 1'b0;
  endtask

  task automatic respond(input logic err);
    resp_valid_i = 1'b1; resp_err_i = err;
    tick();
    resp_valid_i = 1'b0; resp_err_i = 1'b0;
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R11 reset state
    chk("R11 status", 32'(raw_stat_o), 0);
    chk("R11 irq", 32'(irq_o), 0);
    chk("R11 ready", 32'(req_ready_o), 1);
    chk("R11 bus_valid", 32'(bus_valid_o), 0);

    // R1 / R5 vector walk over the write window
    wb_lo_i = 32'h100; wb_hi_i = 32'h1FF; wb_en_i = 1'b1;
    tick();
    for (int i = 0; i < 6; i++) begin
      issue(VEC[i][31:0], VEC[i][32]);
      chk("R1 forward", 32'(bus_valid_o), 32'(!VEC[i][33]));
      if (!VEC[i][33]) chk("R1 address", bus_addr_o, VEC[i][31:0]);
      chk("R5 window bit", 32'(raw_stat_o[3]), 32'(VEC[i][33]));
      chk("R5 gate", 32'(req_ready_o), 32'(!VEC[i][33]));
      if (!VEC[i][33]) respond(1'b0);
      else begin
        wb_en_i = 1'b0; tick();
        wb_en_i = 1'b1; tick();
        chk("R5 release by enable", 32'(req_ready_o), 1);
      end
      clear_all();
    end

    // R5 release by moving the upper bound
    issue(32'h300, 1'b1);
    chk("R5 blocked", 32'(req_ready_o), 0);
    issue(32'h150, 1'b1);
    chk("R5 legal write held", 32'(bus_valid_o), 0);
    wb_hi_i = 32'h3FF; tick();
    chk("R5 release by bound", 32'(req_ready_o), 1);
    wb_en_i = 1'b0; clear_all();

    // R2 stop with one transaction in flight
    issue(32'h40, 1'b0);
    chk("R1 read issued", 32'(bus_valid_o), 1);
    stop_cmd_i = 1'b1; tick(); stop_cmd_i = 1'b0;
    chk("R2 gate closed", 32'(req_ready_o), 0);
    tick();
    chk("R2 not drained", 32'(raw_stat_o[0]), 0);
    respond(1'b0);
    chk("R2 not yet stopped", 32'(raw_stat_o[0]), 0);
    tick();
    chk("R2 stopped", 32'(raw_stat_o[0]), 1);
    issue(32'h44, 1'b0);
    chk("R2 no issue while stopped", 32'(bus_valid_o), 0);

    // R4 start and simultaneous start/stop
    start_cmd_i = 1'b1; tick(); start_cmd_i = 1'b0;
    chk("R4 reopen", 32'(req_ready_o), 1);
    clear_all();
    stop_cmd_i = 1'b1; start_cmd_i = 1'b1; tick();
    stop_cmd_i = 1'b0; start_cmd_i = 1'b0;
    chk("R4 stop wins", 32'(req_ready_o), 0);
    start_cmd_i = 1'b1; tick(); start_cmd_i = 1'b0;
    chk("R4 reopen again", 32'(req_ready_o), 1);
    clear_all();

    // R3 counter limits
    lim0_i = 16'd100; cnt0_i = 16'd100; tick();
    chk("R3 equal is not over", 32'(raw_stat_o[1]), 0);
    cnt0_i = 16'd101; tick();
    chk("R3 limit0 bit", 32'(raw_stat_o[1]), 1);
    chk("R3 gate closed", 32'(req_ready_o), 0);
    chk("R3 stop not yet", 32'(raw_stat_o[0]), 0);
    tick();
    chk("R3 stop follows", 32'(raw_stat_o[0]), 1);
    start_cmd_i = 1'b1; tick(); start_cmd_i = 1'b0;
    chk("R4 start after limit", 32'(req_ready_o), 1);
    clear_all();
    tick();
    chk("R3 no retrigger", 32'(raw_stat_o), 0);
    cnt0_i = '0;
    lim1_i = 16'd4; cnt1_i = 16'd5; tick();
    chk("R3 limit1 bit", 32'(raw_stat_o[2]), 1);
    chk("R3 limit1 gate", 32'(req_ready_o), 0);
    cnt1_i = '0; start_cmd_i = 1'b1; tick(); start_cmd_i = 1'b0;
    clear_all();

    // R8 watchdog hint
    wdog_hit_i = 1'b1; tick(); wdog_hit_i = 1'b0;
    chk("R8 bit", 32'(raw_stat_o), 32'h40);
    chk("R8 ready kept", 32'(req_ready_o), 1);
    issue(32'h80, 1'b1);
    chk("R8 traffic flows", 32'(bus_valid_o), 1);
    respond(1'b0);

    // R10 interrupt masking
    chk("R10 masked", 32'(irq_o), 0);
    mask_i = 7'h40; tick();
    chk("R10 raised", 32'(irq_o), 1);

    // R9 partial clear and set-wins
    clr_we_i = 1'b1; clr_data_i = 7'h01; tick(); clr_we_i = 1'b0;
    chk("R9 other bits kept", 32'(raw_stat_o), 32'h40);
    clr_we_i = 1'b1; clr_data_i = 7'h40; wdog_hit_i = 1'b1; tick();
    clr_we_i = 1'b0; wdog_hit_i = 1'b0;
    chk("R9 set wins", 32'(raw_stat_o), 32'h40);
    clr_we_i = 1'b1; clr_data_i = 7'h40; tick(); clr_we_i = 1'b0;
    chk("R9 cleared", 32'(raw_stat_o), 0);
    chk("R10 dropped", 32'(irq_o), 0);
    mask_i = '0;

    // R7 forced hang
    force_hang_i = 1'b1; tick(); force_hang_i = 1'b0;
    chk("R7 bit", 32'(raw_stat_o[5]), 1);
    chk("R7 gate", 32'(req_ready_o), 0);
    start_cmd_i = 1'b1; tick(); start_cmd_i = 1'b0;
    chk("R7 start ignored", 32'(req_ready_o), 0);
    do_reset();
    chk("R11 after hang", 32'(req_ready_o), 1);
    chk("R11 status after hang", 32'(raw_stat_o), 0);

    // R6 error response
    issue(32'h10, 1'b0);
    respond(1'b1);
    chk("R6 bit", 32'(raw_stat_o[4]), 1);
    chk("R6 gate", 32'(req_ready_o), 0);
    start_cmd_i = 1'b1; tick(); start_cmd_i = 1'b0;
    chk("R6 start ignored", 32'(req_ready_o), 0);
    do_reset();
    chk("R6 reset reopens", 32'(req_ready_o), 1);

    done = 1;
    summary();
  end
endmodule